// File: doc/BRIEF.md
# Three-to-one width conversion buffer

This block is a storage buffer that is written in wide words and read back in narrow words. Each write delivers a 96-bit word to a row address. The read side then returns that word as three 32-bit pieces, least significant piece first. Internally every row holds four 32-bit lanes, so all storage lanes have a power-of-two width. The fourth lane in each row is padding. It is written with zeros and no read can ever select it.

There are two ways to read. In random mode, the narrow read address is split into a row (the address divided by three) and a lane (the address modulo three). A small restoring-division circuit does this split, with no multiplier. In sequential mode, a lane counter that wraps after three steps and a row counter that advances on each wrap produce the next address, so no division is used.

A two-state controller chooses the mode. The two states are `ST_RANDOM` (the reset state) and `ST_SEQ`. There are three transitions:
- `T_ENTER`: a start pulse in `ST_RANDOM` moves the controller to `ST_SEQ` and clears the counters.
- `T_RESTART`: a start pulse in `ST_SEQ` stays in `ST_SEQ` and clears the counters again.
- `T_LEAVE`: a stop pulse in `ST_SEQ`, without a start pulse, returns the controller to `ST_RANDOM`.

Top module: `wide_narrow_buf`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in row `wr_row`. Bits 31:0 become lane 0, bits 63:32 become lane 1, and bits 95:64 become lane 2. Lane L of row R is read at narrow index 3*R+L.
- R2: In random mode, a read of address A (A below 3*ROWS) returns lane A mod 3 of row A div 3. The result appears on the clock edge after the cycle in which `rd_en` is high, and `rd_valid` is high for exactly that one cycle.
- R3: After any cycle with `rd_en` low, `rd_valid` is low. Whenever `rd_valid` is low, `rd_data` is zero.
- R4: In random mode, a read address of 3*ROWS or more produces `rd_valid` low and `rd_data` zero in the following cycle.
- R5: In sequential mode, each read returns the next narrow word in this order: lanes 0, 1 and 2 of a row, then lane 0 of the next row. After lane 2 of the last row, the order wraps to row 0, lane 0. `rd_addr` is ignored in this mode, and the padding lane is never returned.
- R6: `seq_start` (transitions `T_ENTER` and `T_RESTART`) sets the position to row 0, lane 0, starting with the next cycle. A read in the same cycle as `seq_start` or `seq_stop` still uses the mode and position from before the pulse. When both pulses arrive together, `seq_start` wins.
- R7: `seq_stop` in sequential mode (transition `T_LEAVE`) returns the block to random mode from the next cycle.
- R8: A read and a write to the same row in the same cycle return the row's old contents. The new contents can be read from the next cycle on.
- R9: After reset, the block is in random mode with `rd_valid` low and `rd_data` zero.
- R10: A cycle with `wr_en` low leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the wide port |
| wr_row | input | ROW_W (4) | Row written by the wide port |
| wr_data | input | 96 | Wide word to store |
| rd_en | input | 1 | Narrow read request |
| rd_addr | input | NA_W (6) | Narrow word index used in random mode |
| seq_start | input | 1 | Enter or restart sequential mode at row 0, lane 0 |
| seq_stop | input | 1 | Leave sequential mode |
| rd_data | output | 32 | Narrow read word, zero when not valid |
| rd_valid | output | 1 | Marks the cycle that carries read data |

## Verification
The assertions check several properties on every cycle:
- Valid is raised one cycle after an accepted read.
- Valid stays low after idle cycles and after out-of-range random addresses.
- Data is zero whenever valid is low.
- The lane counter never reaches the padding lane.
- The counter steps by one within a row.
- A start pulse clears the position.

Only the bench scenarios can show that the returned data is correct. This covers:
- The lane order inside the wide word.
- The divide and modulo mapping at every address.
- Wrap-around after the last row.
- Read-before-write on a shared row.
- How start and stop pulses coinciding with reads are resolved.

// File: rtl/wnb_pkg.sv
package wnb_pkg;

    // Addressing mode of the narrow read side
    typedef enum logic {
        ST_RANDOM = 1'b0,
        ST_SEQ    = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/wnb_row_store.sv
module wnb_row_store #(
    parameter int ROWS   = 16,
    parameter int LANE_W = 32,
    parameter int RATIO  = 3,
    parameter int LANES  = 4,
    parameter int ROW_W  = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [RATIO*LANE_W-1:0]   wr_data,
    input  logic [ROW_W-1:0]          rd_row,
    output logic [LANES*LANE_W-1:0]   rd_word
);

    localparam int ROW_BITS = LANES * LANE_W;

    logic [ROW_BITS-1:0] mem [ROWS];
    logic [ROW_BITS-1:0] fill;

    // Data lanes take the wide word in order; padding lanes are held at zero
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < RATIO) begin : g_data
            assign fill[g*LANE_W +: LANE_W] = wr_data[g*LANE_W +: LANE_W];
        end else begin : g_pad
            assign fill[g*LANE_W +: LANE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_row) < ROWS)) begin
            mem[wr_row] <= fill;
        end
    end

    // Combinational read; the caller registers the selected lane,
    // which yields old-data behaviour on a same-row collision
    assign rd_word = mem[rd_row];

endmodule

// File: rtl/wnb_addr_split.sv
module wnb_addr_split #(
    parameter int ROWS  = 16,
    parameter int RATIO = 3,
    parameter int NA_W  = 6,
    parameter int ROW_W = 4,
    parameter int LI_W  = 2
) (
    input  logic [NA_W-1:0]  addr,
    output logic [ROW_W-1:0] row,
    output logic [LI_W-1:0]  lane,
    output logic             in_range
);

    localparam int RW = $clog2(RATIO) + 1;

    logic [RW-1:0]   rem;
    logic [NA_W-1:0] quo;

    // Restoring long division by RATIO, one address bit per step
    always_comb begin
        rem = '0;
        quo = '0;
        for (int i = NA_W - 1; i >= 0; i--) begin
            rem = {rem[RW-2:0], addr[i]};
            if (rem >= RW'(RATIO)) begin
                rem    = rem - RW'(RATIO);
                quo[i] = 1'b1;
            end
        end
    end

    assign row      = quo[ROW_W-1:0];
    assign lane     = LI_W'(rem);
    assign in_range = (quo < NA_W'(ROWS));

endmodule

// File: rtl/wnb_seq_ctrl.sv
module wnb_seq_ctrl
    import wnb_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int RATIO = 3,
    parameter int ROW_W = 4,
    parameter int LI_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             seq_start,
    input  logic             seq_stop,
    output logic             seq_active,
    output logic [ROW_W-1:0] seq_row,
    output logic [LI_W-1:0]  seq_lane
);

    localparam logic [LI_W-1:0]  LAST_LANE = LI_W'(RATIO - 1);
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);

    rd_mode_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RANDOM;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: T_ENTER, T_RESTART, T_LEAVE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RANDOM: if (seq_start) state_nx = ST_SEQ;
            ST_SEQ: begin
                if (seq_start)      state_nx = ST_SEQ;
                else if (seq_stop)  state_nx = ST_RANDOM;
            end
        endcase
    end

    // Outputs
    always_comb begin
        seq_active = 1'b0;
        unique case (state)
            ST_RANDOM: seq_active = 1'b0;
            ST_SEQ:    seq_active = 1'b1;
        endcase
    end

    // Lane and row counters; lane wraps at RATIO, row steps on each wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_row  <= '0;
            seq_lane <= '0;
        end else if (seq_start) begin
            seq_row  <= '0;
            seq_lane <= '0;
        end else if (seq_active && rd_en) begin
            if (seq_lane == LAST_LANE) begin
                seq_lane <= '0;
                seq_row  <= (seq_row == LAST_ROW) ? '0 : seq_row + 1'b1;
            end else begin
                seq_lane <= seq_lane + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wide_narrow_buf.sv
module wide_narrow_buf #(
    parameter int ROWS   = 16,
    parameter int LANE_W = 32,
    parameter int RATIO  = 3,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int NA_W   = $clog2(RATIO * ROWS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [RATIO*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [NA_W-1:0]         rd_addr,
    input  logic                    seq_start,
    input  logic                    seq_stop,
    output logic [LANE_W-1:0]       rd_data,
    output logic                    rd_valid
);

    localparam int LI_W  = $clog2(RATIO);
    localparam int LANES = 1 << LI_W;

    logic [LANES*LANE_W-1:0] row_word;
    logic [ROW_W-1:0]        split_row, seq_row, sel_row;
    logic [LI_W-1:0]         split_lane, seq_lane, sel_lane;
    logic                    split_ok, seq_active, sel_ok;

    wnb_row_store #(
        .ROWS(ROWS), .LANE_W(LANE_W), .RATIO(RATIO),
        .LANES(LANES), .ROW_W(ROW_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .rd_row(sel_row), .rd_word(row_word)
    );

    wnb_addr_split #(
        .ROWS(ROWS), .RATIO(RATIO), .NA_W(NA_W),
        .ROW_W(ROW_W), .LI_W(LI_W)
    ) u_split (
        .addr(rd_addr), .row(split_row), .lane(split_lane), .in_range(split_ok)
    );

    wnb_seq_ctrl #(
        .ROWS(ROWS), .RATIO(RATIO), .ROW_W(ROW_W), .LI_W(LI_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .seq_start(seq_start), .seq_stop(seq_stop),
        .seq_active(seq_active), .seq_row(seq_row), .seq_lane(seq_lane)
    );

    assign sel_row  = seq_active ? seq_row  : split_row;
    assign sel_lane = seq_active ? seq_lane : split_lane;
    assign sel_ok   = seq_active | split_ok;

    // Registered narrow output, zero whenever not valid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (rd_en && sel_ok) begin
            rd_valid <= 1'b1;
            rd_data  <= row_word[sel_lane*LANE_W +: LANE_W];
        end else begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end
    end

endmodule

// File: rtl/wnb_checker.sv
module wnb_checker #(
    parameter int ROWS   = 16,
    parameter int LANE_W = 32,
    parameter int RATIO  = 3,
    parameter int ROW_W  = 4,
    parameter int NA_W   = 6,
    parameter int LI_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [NA_W-1:0]   rd_addr,
    input logic              seq_start,
    input logic              seq_active,
    input logic [ROW_W-1:0]  seq_row,
    input logic [LI_W-1:0]   seq_lane,
    input logic [LANE_W-1:0] rd_data,
    input logic              rd_valid
);

    localparam logic [NA_W:0] NARROW = (NA_W + 1)'(RATIO * ROWS);

    logic addr_hi;
    assign addr_hi = ({1'b0, rd_addr} >= NARROW);

    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r3_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    a_r4_oob_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !seq_active && addr_hi) |=> !rd_valid);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (seq_active || !addr_hi)) |=> rd_valid);

    a_r5_no_pad_lane: assert property (@(posedge clk) disable iff (!rst_n)
        seq_lane < LI_W'(RATIO));

    a_r5_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && rd_en && !seq_start && seq_lane != LI_W'(RATIO - 1))
        |=> (seq_lane == $past(seq_lane) + 1'b1) && (seq_row == $past(seq_row)));

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (seq_active && seq_row == '0 && seq_lane == '0));

endmodule

bind wide_narrow_buf wnb_checker #(
    .ROWS(ROWS), .LANE_W(LANE_W), .RATIO(RATIO),
    .ROW_W(ROW_W), .NA_W(NA_W), .LI_W(LI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .seq_start(seq_start), .seq_active(seq_active), .seq_row(seq_row),
    .seq_lane(seq_lane), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/wide_narrow_buf_tb.sv
`timescale 1ns/1ps
module wide_narrow_buf_tb;

    localparam int ROWS = 16;
    localparam int W    = 32;
    localparam int RW   = 4;
    localparam int AW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [RW-1:0] wr_row = '0;
    logic [95:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          seq_start = 1'b0;
    logic          seq_stop = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model
    logic [95:0] m_mem [ROWS];
    bit          m_seq = 1'b0;
    int          m_row = 0;
    int          m_lane = 0;

    always #2 clk = ~clk;

    wide_narrow_buf u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .seq_start(seq_start), .seq_stop(seq_stop),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [W-1:0] exp_word(int idx);
        logic [95:0] w = m_mem[idx / 3];
        return w[(idx % 3) * W +: W];
    endfunction

    function automatic logic [95:0] rnd96();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic compare(string tag, logic ev, logic [W-1:0] ed);
        checks++;
        if (rd_valid !== ev || rd_data !== ed) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     tag, rd_valid, rd_data, ev, ed);
        end
    endtask

    // One cycle: apply inputs, predict, clock, compare just after the edge
    task automatic step(bit we, int wrow, logic [95:0] wd, bit re, int addr,
                        bit st, bit sp, string tag);
        logic          ev = 1'b0;
        logic [W-1:0]  ed = '0;
        if (re) begin
            if (m_seq) begin
                ev = 1'b1; ed = exp_word(m_row * 3 + m_lane);
            end else if (addr < 3 * ROWS) begin
                ev = 1'b1; ed = exp_word(addr);
            end
        end
        wr_en = we; wr_row = RW'(wrow); wr_data = wd;
        rd_en = re; rd_addr = AW'(addr);
        seq_start = st; seq_stop = sp;
        @(posedge clk);
        #1;
        if (we) m_mem[wrow] = wd;
        if (st) begin
            m_seq = 1'b1; m_row = 0; m_lane = 0;
        end else begin
            if (m_seq && re) begin
                if (m_lane == 2) begin
                    m_lane = 0; m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
                end else m_lane++;
            end
            if (sp) m_seq = 1'b0;
        end
        compare(tag, ev, ed);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = int'($urandom(32'h5EED));
        #9;
        // R9: reset state
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0) begin
            errors++;
            $display("FAIL R9: got valid=%0b data=%h, expected 0/0", rd_valid, rd_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill every row, lanes distinct
        for (int r = 0; r < ROWS; r++)
            step(1, r, {8'(r), 24'hC00002, 8'(r), 24'hB00001, 8'(r), 24'hA00000},
                 0, 0, 0, 0, "R1 fill");
        // R9: reset leaves random mode (address 4 selects row 1 lane 1)
        step(0, 0, '0, 1, 4, 0, 0, "R9 random after reset");
        // R1, R2: every narrow address
        for (int a = 0; a < 3 * ROWS; a++)
            step(0, 0, '0, 1, a, 0, 0, "R1 R2 random map");
        // R3: idle cycle
        step(0, 0, '0, 0, 5, 0, 0, "R3 idle");
        // R4: out of range
        step(0, 0, '0, 1, 48, 0, 0, "R4 addr 48");
        step(0, 0, '0, 1, 63, 0, 0, "R4 addr 63");
        // R10: write enable low with data present
        step(0, 5, rnd96(), 0, 0, 0, 0, "R10 no write");
        step(0, 0, '0, 1, 15, 0, 0, "R10 row5 lane0");
        step(0, 0, '0, 1, 17, 0, 0, "R10 row5 lane2");
        // R8: read-before-write on row 7
        step(1, 7, 96'h111111112222222233333333, 1, 21, 0, 0, "R8 old data");
        step(0, 0, '0, 1, 21, 0, 0, "R8 new data");
        // R5: sequential run across wrap, rd_addr random
        step(0, 0, '0, 0, 0, 1, 0, "R6 enter");
        for (int i = 0; i < 3 * ROWS + 5; i++)
            step(0, 0, '0, 1, int'($urandom_range(0, 63)), 0, 0, "R5 sequential");
        // R6: start with read in same cycle uses prior position, then restart
        step(0, 0, '0, 1, 0, 1, 0, "R6 read with restart");
        step(0, 0, '0, 1, 9, 0, 0, "R6 after restart");
        // R6: start and stop together, start wins
        step(0, 0, '0, 1, 9, 1, 1, "R6 start wins");
        step(0, 0, '0, 1, 9, 0, 0, "R6 still sequential");
        // R7: stop, read in same cycle still sequential, then random
        step(0, 0, '0, 1, 9, 0, 1, "R7 read with stop");
        step(0, 0, '0, 1, 9, 0, 0, "R7 random again");
        // R6: enter from random with read in same cycle uses random address
        step(0, 0, '0, 1, 30, 1, 0, "R6 enter with read");
        step(0, 0, '0, 1, 30, 0, 0, "R6 first sequential");
        step(0, 0, '0, 0, 0, 0, 1, "R7 leave");

        // Random mix covering R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 600; i++) begin
            bit we = ($urandom_range(0, 1) == 1);
            bit re = ($urandom_range(0, 9) < 7);
            bit st = ($urandom_range(0, 29) == 0);
            bit sp = ($urandom_range(0, 29) == 0);
            step(we, int'($urandom_range(0, ROWS - 1)), rnd96(), re,
                 int'($urandom_range(0, 63)), st, sp, "R2 R5 R8 random mix");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule